// File: doc/BRIEF.md
# Two-Port Semaphore Flag Bank

This block holds a small bank of binary token flags that two independent ports share, a left port and a right port. Software on either side takes a flag as a lock on some shared resource whose meaning it alone decides. The flags are kept apart from any data memory and control nothing in hardware. A port reaches the flags only while its own flag select is high.

To claim a flag, a port writes a 0 to it. It then reads the flag back. A read value of 0 means the port now holds the token. A read value of 1 means the other side holds it. A claim made while the other side holds the flag is not lost: it stays queued, and when the holder writes a 1 to give the flag up, ownership passes to the queued side on that edge. When both ports claim the same free flag in the same cycle, the left port wins and the right port's claim is queued, so the outcome is never ambiguous.

Writes take effect on the rising clock edge. Reads are combinational and return the state as it stands before the edge.

Top module: `sem_bank`

## Requirements
- R1: After a synchronous reset all eight flags are free, no claims are queued, and a read of any flag from either port returns 1.
- R2: While a port's select is low, its write has no effect and its read data is 1.
- R3: A write of 0 to a free flag makes the writer its owner from the next clock edge on. From that edge, the writer reads 0 from that flag and the other port reads 1.
- R4: A read (write strobe low) returns 0 only to the current owner of the addressed flag. It returns 1 for a free flag, to a queued claimant and to the other port, and it changes no state.
- R5: A write of 0 from a port while the other port owns the flag queues the claim. When the owner writes 1, the queued port becomes owner on that edge.
- R6: When both ports write 0 to the same free flag in one cycle, the left port becomes owner and the right port's claim is queued.
- R7: A write of 1 from a port that neither owns the flag nor has a claim queued on it has no effect. A write of 1 from the queued port withdraws its claim, so a later release by the owner leaves the flag free.
- R8: No flag is ever owned by both ports, and two ports reading the same flag never both get 0.
- R9: The eight flags are independent. An access to one flag index leaves every other flag unchanged.
- R10: When the owner releases a flag in the same cycle the other port claims it, the other port becomes owner on that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sel_l | input | 1 | Left port flag select |
| idx_l | input | 3 | Left port flag index |
| wr_l | input | 1 | Left port write strobe |
| wdata_l | input | 1 | Left port write bit (0 claim, 1 release) |
| rdata_l | output | 1 | Left port read bit (0 owned by left) |
| sel_r | input | 1 | Right port flag select |
| idx_r | input | 3 | Right port flag index |
| wr_r | input | 1 | Right port write strobe |
| wdata_r | input | 1 | Right port write bit (0 claim, 1 release) |
| rdata_r | output | 1 | Right port read bit (0 owned by right) |

## Verification
A wrong owner bit shows up at the read port in the very next cycle in which that flag is addressed. The bench therefore reads a flag from both sides right after every claim and release. A lost or stray queued claim stays hidden until the owner releases, so the release sequences are followed by reads from both ports. Those reads show whether the flag went to the queued side or back to free. Damage to a neighbouring flag is caught by reading other indices after each operation and by sweeping all eight flags.

// File: rtl/sem_pkg.sv
package sem_pkg;
    typedef struct packed {
        logic own_l;
        logic own_r;
        logic pend;   // queued claim of the side that does not own
    } flag_st_t;
endpackage

// File: rtl/sem_port_dec.sv
module sem_port_dec #(
    parameter int NUM_FLAGS = 8,
    parameter int IDX_W     = $clog2(NUM_FLAGS)
) (
    input  logic                 sel,
    input  logic [IDX_W-1:0]     idx,
    input  logic                 wr,
    input  logic                 wdata,
    output logic [NUM_FLAGS-1:0] req,
    output logic [NUM_FLAGS-1:0] rel
);
    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_dec
        logic hit;
        assign hit    = sel && wr && (idx == IDX_W'(g));
        assign req[g] = hit && !wdata;
        assign rel[g] = hit &&  wdata;
    end
endmodule

// File: rtl/sem_flag_cell.sv
module sem_flag_cell
    import sem_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_l,
    input  logic rel_l,
    input  logic req_r,
    input  logic rel_r,
    output logic own_l,
    output logic own_r,
    output logic pend
);
    flag_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // releases first, left then right
        if (rel_l) begin
            if (st_d.own_l) begin
                st_d.own_l = 1'b0;
                st_d.own_r = st_d.pend;
                st_d.pend  = 1'b0;
            end else if (st_d.own_r && st_d.pend) begin
                st_d.pend  = 1'b0;
            end
        end
        if (rel_r) begin
            if (st_d.own_r) begin
                st_d.own_r = 1'b0;
                st_d.own_l = st_d.pend;
                st_d.pend  = 1'b0;
            end else if (st_d.own_l && st_d.pend) begin
                st_d.pend  = 1'b0;
            end
        end
        // claims next, left first so a tie goes left
        if (req_l && !st_d.own_l) begin
            if (st_d.own_r) st_d.pend  = 1'b1;
            else            st_d.own_l = 1'b1;
        end
        if (req_r && !st_d.own_r) begin
            if (st_d.own_l) st_d.pend  = 1'b1;
            else            st_d.own_r = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign own_l = st_q.own_l;
    assign own_r = st_q.own_r;
    assign pend  = st_q.pend;
endmodule

// File: rtl/sem_bank.sv
module sem_bank #(
    parameter int NUM_FLAGS = 8,
    parameter int IDX_W     = $clog2(NUM_FLAGS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sel_l,
    input  logic [IDX_W-1:0] idx_l,
    input  logic             wr_l,
    input  logic             wdata_l,
    output logic             rdata_l,
    input  logic             sel_r,
    input  logic [IDX_W-1:0] idx_r,
    input  logic             wr_r,
    input  logic             wdata_r,
    output logic             rdata_r
);
    logic [NUM_FLAGS-1:0] req_l_v, rel_l_v, req_r_v, rel_r_v;
    logic [NUM_FLAGS-1:0] own_l_vec, own_r_vec, pend_vec;

    sem_port_dec #(.NUM_FLAGS(NUM_FLAGS), .IDX_W(IDX_W)) u_dec_l (
        .sel(sel_l), .idx(idx_l), .wr(wr_l), .wdata(wdata_l),
        .req(req_l_v), .rel(rel_l_v)
    );

    sem_port_dec #(.NUM_FLAGS(NUM_FLAGS), .IDX_W(IDX_W)) u_dec_r (
        .sel(sel_r), .idx(idx_r), .wr(wr_r), .wdata(wdata_r),
        .req(req_r_v), .rel(rel_r_v)
    );

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        sem_flag_cell u_cell (
            .clk   (clk),
            .rst   (rst),
            .req_l (req_l_v[g]),
            .rel_l (rel_l_v[g]),
            .req_r (req_r_v[g]),
            .rel_r (rel_r_v[g]),
            .own_l (own_l_vec[g]),
            .own_r (own_r_vec[g]),
            .pend  (pend_vec[g])
        );
    end

    always_comb begin
        rdata_l = !(sel_l && own_l_vec[idx_l]);
        rdata_r = !(sel_r && own_r_vec[idx_r]);
    end
endmodule

// File: rtl/sem_bank_chk.sv
module sem_bank_chk #(
    parameter int NUM_FLAGS = 8,
    parameter int IDX_W     = $clog2(NUM_FLAGS)
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 sel_l,
    input logic [IDX_W-1:0]     idx_l,
    input logic                 wr_l,
    input logic                 wdata_l,
    input logic                 rdata_l,
    input logic                 sel_r,
    input logic [IDX_W-1:0]     idx_r,
    input logic                 wr_r,
    input logic                 wdata_r,
    input logic                 rdata_r,
    input logic [NUM_FLAGS-1:0] own_l_vec,
    input logic [NUM_FLAGS-1:0] own_r_vec,
    input logic [NUM_FLAGS-1:0] pend_vec
);
    logic claim_l, claim_r, free_l;
    assign claim_l = sel_l && wr_l && !wdata_l;
    assign claim_r = sel_r && wr_r && !wdata_r;
    assign free_l  = !own_l_vec[idx_l] && !own_r_vec[idx_l];

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (own_l_vec == '0 && own_r_vec == '0 && pend_vec == '0));

    // R8
    no_double_owner_chk: assert property (@(posedge clk) disable iff (rst)
        (own_l_vec & own_r_vec) == '0);

    // R8
    port_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        (sel_l && sel_r && idx_l == idx_r) |-> (rdata_l || rdata_r));

    // R5
    pend_needs_owner_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_vec & ~(own_l_vec | own_r_vec)) == '0);

    // R3
    grant_free_chk: assert property (@(posedge clk) disable iff (rst)
        (claim_l && free_l && !(sel_r && wr_r && idx_r == idx_l))
        |=> own_l_vec[$past(idx_l)]);

    // R6
    tie_left_chk: assert property (@(posedge clk) disable iff (rst)
        (claim_l && claim_r && idx_l == idx_r && free_l)
        |=> (own_l_vec[$past(idx_l)] && pend_vec[$past(idx_l)]));
endmodule

bind sem_bank sem_bank_chk #(.NUM_FLAGS(NUM_FLAGS), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst(rst),
    .sel_l(sel_l), .idx_l(idx_l), .wr_l(wr_l), .wdata_l(wdata_l), .rdata_l(rdata_l),
    .sel_r(sel_r), .idx_r(idx_r), .wr_r(wr_r), .wdata_r(wdata_r), .rdata_r(rdata_r),
    .own_l_vec(own_l_vec), .own_r_vec(own_r_vec), .pend_vec(pend_vec)
);

// File: tb/tb_sem_bank.sv
module tb_sem_bank;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 21;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sel_l = 0, wr_l = 0, wdata_l = 0;
    logic       sel_r = 0, wr_r = 0, wdata_r = 0;
    logic [2:0] idx_l = '0, idx_r = '0;
    logic       rdata_l, rdata_r;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sem_bank dut (
        .clk(clk), .rst(rst),
        .sel_l(sel_l), .idx_l(idx_l), .wr_l(wr_l), .wdata_l(wdata_l), .rdata_l(rdata_l),
        .sel_r(sel_r), .idx_r(idx_r), .wr_r(wr_r), .wdata_r(wdata_r), .rdata_r(rdata_r)
    );

    // {sel_l, idx_l, wr_l, wdata_l, sel_r, idx_r, wr_r, wdata_r, exp_rdata_l, exp_rdata_r}
    // Expected read values show the state before the row's own write.
    localparam logic [13:0] VEC [NVEC] = '{
        14'b1_000_0_0_0_000_0_0_1_1, //  0 R1 free after reset
        14'b1_000_1_0_0_000_0_0_1_1, //  1 R3 left claims 0
        14'b1_000_0_0_1_000_0_0_0_1, //  2 R3 R4 left owns 0
        14'b1_000_0_0_1_000_1_0_0_1, //  3 R5 right queues on 0
        14'b1_000_1_1_1_000_0_0_0_1, //  4 R5 left releases 0
        14'b1_000_0_0_1_000_0_0_1_0, //  5 R5 right now owns 0
        14'b1_000_1_1_1_000_0_0_1_0, //  6 R7 stray release by left
        14'b1_000_0_0_1_000_0_0_1_0, //  7 R7 right still owns 0
        14'b1_011_1_0_1_011_1_0_1_1, //  8 R6 tie on 3
        14'b1_011_0_0_1_011_0_0_0_1, //  9 R6 left won 3
        14'b1_011_0_0_1_011_1_1_0_1, // 10 R7 right withdraws
        14'b1_011_1_1_1_011_0_0_0_1, // 11 R7 left releases 3
        14'b1_011_0_0_1_011_0_0_1_1, // 12 R7 3 is free
        14'b0_101_1_0_0_000_0_0_1_1, // 13 R2 unselected claim
        14'b1_101_0_0_1_101_1_0_1_1, // 14 R2 5 still free, right claims
        14'b1_111_0_0_1_101_0_0_1_0, // 15 R9 right owns 5, 7 free
        14'b1_010_1_0_1_010_0_0_1_1, // 16 R10 left claims 2
        14'b1_010_1_1_1_010_1_0_0_1, // 17 R10 release and claim together
        14'b1_010_0_0_1_010_0_0_1_0, // 18 R10 right owns 2
        14'b1_000_0_0_1_000_0_0_1_0, // 19 R9 flag 0 untouched
        14'b1_000_0_0_0_000_0_0_1_1  // 20 R2 unselected read is 1
    };

    function automatic string vec_tag(int i);
        case (i)
            0:                   return "R1";
            1, 2:                return "R3";
            3, 4, 5:             return "R5";
            6, 7, 10, 11, 12:    return "R7";
            8, 9:                return "R6";
            13, 14, 20:          return "R2";
            15, 19:              return "R9";
            default:             return "R10";
        endcase
    endfunction

    task automatic check(string tag, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    task automatic drive(logic sl, logic [2:0] il, logic wl, logic dl,
                         logic sr, logic [2:0] ir, logic wr, logic dr);
        sel_l = sl; idx_l = il; wr_l = wl; wdata_l = dl;
        sel_r = sr; idx_r = ir; wr_r = wr; wdata_r = dr;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            drive(VEC[i][13], VEC[i][12:10], VEC[i][9], VEC[i][8],
                  VEC[i][7], VEC[i][6:4], VEC[i][3], VEC[i][2]);
            #1;
            check(vec_tag(i), $sformatf("row %0d left", i),  rdata_l, VEC[i][1]);
            check(vec_tag(i), $sformatf("row %0d right", i), rdata_r, VEC[i][0]);
        end

        // R1: reset in the middle of activity clears every flag
        @(negedge clk);
        drive(0, 0, 0, 0, 0, 0, 0, 0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int f = 0; f < 8; f++) begin
            drive(1, 3'(f), 0, 0, 1, 3'(f), 0, 0);
            #1;
            check("R1", $sformatf("flag %0d left after reset", f),  rdata_l, 1'b1);
            check("R1", $sformatf("flag %0d right after reset", f), rdata_r, 1'b1);
        end

        // R9: left claims all flags one at a time
        for (int f = 0; f < 8; f++) begin
            @(negedge clk);
            drive(1, 3'(f), 1, 0, 0, 0, 0, 0);
        end
        @(negedge clk);
        drive(0, 0, 0, 0, 0, 0, 0, 0);
        for (int f = 0; f < 8; f++) begin
            drive(1, 3'(f), 0, 0, 1, 3'(f), 0, 0);
            #1;
            check("R9", $sformatf("flag %0d left owns", f),  rdata_l, 1'b0);
            check("R4", $sformatf("flag %0d right reads", f), rdata_r, 1'b1);
        end

        // R8: right claims every flag, left keeps them all
        for (int f = 0; f < 8; f++) begin
            @(negedge clk);
            drive(0, 0, 0, 0, 1, 3'(f), 1, 0);
        end
        @(negedge clk);
        drive(0, 0, 0, 0, 0, 0, 0, 0);
        for (int f = 0; f < 8; f++) begin
            drive(1, 3'(f), 0, 0, 1, 3'(f), 0, 0);
            #1;
            check("R8", $sformatf("flag %0d left keeps", f), rdata_l, 1'b0);
            check("R8", $sformatf("flag %0d right queued", f), rdata_r, 1'b1);
        end

        // R5: left releases flag 6, queued right takes it
        @(negedge clk);
        drive(1, 3'd6, 1, 1, 0, 0, 0, 0);
        @(negedge clk);
        drive(1, 3'd6, 0, 0, 1, 3'd6, 0, 0);
        #1;
        check("R5", "flag 6 left after release", rdata_l, 1'b1);
        check("R5", "flag 6 right granted",      rdata_r, 1'b0);

        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule